// File: doc/BRIEF.md
# Display Power Sequencer with Frame Guard

This block drives the internal power/enable signal of a display controller. The LCD output pins follow this signal, and software uses it to switch the display module on and off. Software writes an 8-bit control word. One bit gives the requested power state and the other seven bits give a guard interval in frames. The block does not apply the new state at once. It waits for the programmed number of frame-start pulses, so that the pixel FIFOs have time to fill before any data reaches the panel.

The wait applies to switching on and to switching off. A guard field of zero is treated as one frame. Counting starts at the first frame pulse after the write cycle. A frame pulse in the write cycle itself does not count. A second write while a change is pending cancels the pending change and starts a new countdown with the new request and the new interval. A busy flag shows that a countdown is in progress. A pin-hold output tells the pad logic to keep every data and control pin at its inactive level while power is off.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, pwr_on is 0, busy is 0 and pin_hold is 1.
- R2: In a write, bit 0 of cfg_wdata is the requested power state and bits 7:1 are the guard count N in frames. pwr_on takes the requested value at the clock edge that samples the N-th frame_tick after the write cycle, and the new value is visible in the following cycle.
- R3: The guard delay applies in the same way when switching on (0 to 1) and when switching off (1 to 0).
- R4: A guard field of 0 behaves exactly like a guard field of 1.
- R5: A frame_tick in the same cycle as cfg_we is not counted toward the guard.
- R6: A write while a countdown is pending discards the pending change and restarts the countdown with the new request and count. If the new request equals the current pwr_on, pwr_on does not change.
- R7: busy is 1 from the cycle after a write until the countdown completes. busy is 0 in the cycle after the completing frame_tick.
- R8: pin_hold is 1 exactly while pwr_on is 0.
- R9: While busy is 0, frame_tick pulses change neither pwr_on nor busy.
- R10: pwr_on never changes except at the completion of a countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit 0 is the request, bits 7:1 are the guard frames |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| pwr_on | output | 1 | Display power/enable |
| busy | output | 1 | A countdown is in progress |
| pin_hold | output | 1 | Hold the LCD pins at their inactive level |

## Verification
The checker tests the following properties on every cycle:
- pwr_on moves only on a completion event and then takes the latched request.
- busy rises after every write and stays high until completion.
- The loaded count is never zero while busy, and a zero guard field loads one.
- Idle frame pulses have no effect.
- pin_hold is always the opposite of pwr_on.

Some behaviour can only be shown by the bench scenarios, which measure frame distances:
- Exactly N frames pass between the write and the change, in both directions.
- A frame pulse coinciding with the write is ignored.
- A restart or a cancel rewrites the outcome.
- The largest guard value of 127 frames is honoured.

// File: rtl/disp_pwr_pkg.sv
package disp_pwr_pkg;
  // width of the guard field in the control word
  parameter int unsigned GUARD_BITS = 7;
  // position of the power request bit inside the control word
  parameter int unsigned REQ_POS = 0;
  localparam int unsigned WORD_BITS = GUARD_BITS + 1;

  typedef logic [GUARD_BITS-1:0] guard_t;
  typedef logic [WORD_BITS-1:0]  word_t;

  // effective frame count: a zero field means one frame
  function automatic guard_t eff_guard(input guard_t field);
    return (field == '0) ? guard_t'(1) : field;
  endfunction

  // guard field taken out of a control word
  function automatic guard_t guard_field(input word_t w);
    return w[WORD_BITS-1:1];
  endfunction
endpackage

// File: rtl/dps_cfg_capture.sv
module dps_cfg_capture
  import disp_pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_we,
  input  word_t  cfg_wdata,
  output logic   wr_evt,
  output guard_t guard_load,
  output logic   req_q
);
  assign wr_evt     = cfg_we;
  assign guard_load = eff_guard(guard_field(cfg_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (wr_evt) req_q <= cfg_wdata[REQ_POS];
  end
endmodule

// File: rtl/dps_frame_timer.sv
module dps_frame_timer
  import disp_pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_evt,
  input  guard_t guard_load,
  input  logic   frame_tick,
  output logic   pending,
  output logic   tick_evt,
  output logic   expire_evt,
  output guard_t cnt_q
);
  // a frame pulse counts only while pending and not in a write cycle
  assign tick_evt   = pending && frame_tick && !wr_evt;
  assign expire_evt = tick_evt && (cnt_q == guard_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt_q   <= '0;
    end else if (wr_evt) begin
      pending <= 1'b1;
      cnt_q   <= guard_load;
    end else if (tick_evt) begin
      cnt_q <= cnt_q - guard_t'(1);
      if (expire_evt) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dps_pwr_stage.sv
module dps_pwr_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic req_q,
  output logic pwr_on,
  output logic pin_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_on   <= 1'b0;
      pin_hold <= 1'b1;
    end else if (expire_evt) begin
      pwr_on   <= req_q;
      pin_hold <= !req_q;
    end
  end
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_pwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [WORD_BITS-1:0] cfg_wdata,
  input  logic                 frame_tick,
  output logic                 pwr_on,
  output logic                 busy,
  output logic                 pin_hold
);
  logic   wr_evt;
  logic   tick_evt;
  logic   expire_evt;
  logic   req_q;
  logic   pending;
  guard_t guard_load;
  guard_t cnt_q;

  dps_cfg_capture u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .wr_evt(wr_evt), .guard_load(guard_load), .req_q(req_q)
  );

  dps_frame_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .guard_load(guard_load),
    .frame_tick(frame_tick), .pending(pending), .tick_evt(tick_evt),
    .expire_evt(expire_evt), .cnt_q(cnt_q)
  );

  dps_pwr_stage u_pwr (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .req_q(req_q),
    .pwr_on(pwr_on), .pin_hold(pin_hold)
  );

  assign busy = pending;
endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk
  import disp_pwr_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cfg_we,
  input word_t  cfg_wdata,
  input logic   frame_tick,
  input logic   pwr_on,
  input logic   busy,
  input logic   pin_hold,
  input logic   expire_evt,
  input logic   tick_evt,
  input logic   req_q,
  input guard_t cnt_q
);
  // R10: no change of power without a completion event
  a_r10_pwr_only_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    !expire_evt |=> $stable(pwr_on));

  // R2: completion applies the latched request
  a_r2_pwr_takes_request: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (pwr_on == $past(req_q)));

  // R7: a write makes busy, and busy holds until completion
  a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> busy);
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire_evt) |=> busy);
  a_r7_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !cfg_we) |=> !busy);

  // R4: a zero guard field loads one frame
  a_r4_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[WORD_BITS-1:1] == '0) |=> (cnt_q == guard_t'(1)));

  // R5: a frame pulse in the write cycle is not counted
  a_r5_write_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && frame_tick) |-> !tick_evt);

  // R2: count stays nonzero while waiting
  a_r2_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));

  // R9: idle frame pulses do nothing
  a_r9_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_we) |=> (!busy && $stable(pwr_on)));

  // R8: pin hold opposite to power
  a_r8_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hold != pwr_on);
endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .frame_tick(frame_tick), .pwr_on(pwr_on), .busy(busy), .pin_hold(pin_hold),
  .expire_evt(expire_evt), .tick_evt(tick_evt), .req_q(req_q), .cnt_q(cnt_q)
);

// File: tb/disp_pwr_seq_test.sv
module disp_pwr_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       frame_tick = 1'b0;
  logic       pwr_on, busy, pin_hold;

  int checks = 0;
  int errors = 0;
  int frame_count = 0;
  logic model_pwr = 1'b0;
  bit done = 0;

  typedef struct { logic val; int at_frame; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  disp_pwr_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .frame_tick(frame_tick), .pwr_on(pwr_on), .busy(busy), .pin_hold(pin_hold)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int g);
    return (g == 0) ? 1 : g;
  endfunction

  // driver: a write; push the expected transition
  task automatic wr(input logic req, input int g, input bit with_tick = 0);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {g[6:0], req};
    frame_tick = with_tick;
    sb.delete();  // R6: any pending change is discarded
    if (req != model_pwr)
      sb.push_back('{val: req, at_frame: frame_count + (with_tick ? 1 : 0) + eff(g)});
    @(posedge clk);
    if (with_tick) frame_count++;
    @(negedge clk);
    cfg_we = 1'b0;
    frame_tick = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_tick = 1'b1;
      @(posedge clk);
      frame_count++;
      @(negedge clk);
      frame_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // monitor: compare every power change with the scoreboard
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && pwr_on !== prev) begin
        if (sb.size() == 0) begin
          check("R10 unexpected pwr change", int'(pwr_on), int'(prev));
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R2/R3 pwr value", int'(pwr_on), int'(e.val));
          check("R2/R3 frame of change", frame_count, e.at_frame);
          model_pwr = e.val;
        end
        check("R8 pin_hold", int'(pin_hold), int'(!pwr_on));
        prev = pwr_on;
      end
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pwr_on", int'(pwr_on), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 pin_hold", int'(pin_hold), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 idle frames
    frames(3);
    check("R9 pwr idle", int'(pwr_on), 0);
    check("R9 busy idle", int'(busy), 0);

    // R2/R3 power on with 3 frames
    wr(1'b1, 3);
    check("R7 busy after write", int'(busy), 1);
    frames(2);
    check("R2 still off", int'(pwr_on), 0);
    check("R8 pins held", int'(pin_hold), 1);
    frames(1);
    check("R2 on", int'(pwr_on), 1);
    check("R7 busy clear", int'(busy), 0);
    check("R8 pins released", int'(pin_hold), 0);

    // R4 guard zero, R3 power off
    wr(1'b0, 0);
    check("R4 busy", int'(busy), 1);
    frames(1);
    check("R4 off after one frame", int'(pwr_on), 0);
    check("R4 busy clear", int'(busy), 0);

    // R6 restart
    wr(1'b1, 5);
    frames(2);
    wr(1'b1, 2);
    frames(1);
    check("R6 restart still off", int'(pwr_on), 0);
    frames(1);
    check("R6 restart on", int'(pwr_on), 1);

    // R6 cancel with request equal to current state
    wr(1'b0, 4);
    frames(1);
    wr(1'b1, 1);
    check("R6 busy on cancel", int'(busy), 1);
    frames(1);
    check("R6 cancel busy clear", int'(busy), 0);
    frames(4);
    check("R6 cancel kept on", int'(pwr_on), 1);

    // R5 tick in the write cycle is not counted
    wr(1'b0, 2, 1'b1);
    frames(1);
    check("R5 still on", int'(pwr_on), 1);
    frames(1);
    check("R5 off", int'(pwr_on), 0);

    // R2 maximum guard 127
    wr(1'b1, 127);
    frames(126);
    check("R2 max guard still off", int'(pwr_on), 0);
    check("R7 busy during max", int'(busy), 1);
    frames(1);
    check("R2 max guard on", int'(pwr_on), 1);

    frames(2);
    check("R10 scoreboard drained", sb.size(), 0);
    finish_up();
  end
endmodule